// File: doc/BRIEF.md
# PRBS-7 Loopback Link Tester

This block exercises a parallel lane group whose outputs are wired back to its inputs through an external loopback path. A transmit generator emits words built from a 7-bit maximal-length pseudo-random sequence. A receive checker then works out how many words the round trip takes. It tries each candidate delay in turn and confirms the chosen one over a run of clean words. Once confirmed, it compares every returned word with the one that was sent, bit by bit.

The received word and the per-bit mismatch vector are both presented as registered outputs, so they can be watched as waveforms. A lock flag reports alignment. A saturating counter totals the mismatching bits seen while locked. A one-cycle inject strobe corrupts exactly one future word, which proves that the checker sees real errors. The active pattern width can be narrowed at run time to any number of low-order lanes.

Both data paths use a valid/ready handshake. A transmit word advances only on a cycle where `tx_valid` and `tx_ready` are both high; while `tx_ready` is low the word on `tx_data` is held unchanged. The checker never applies back-pressure: `rx_ready` is high whenever the block is out of reset, and every cycle with `rx_valid` high delivers one word. Round-trip delay is measured in handshaken transmit words, so the loopback is expected to keep the transmit side flowing.

Top module: `prbs_link_tester`

## Requirements
- R1: After reset the generator state is 7'h7F. Each new pattern bit is state bit 6 XOR state bit 5; that bit is shifted into state bit 0, and a word is filled from bit 0 upward with successive new bits. The first word after reset is built from the seed in this way.
- R2: `wsel` sets the number of active low-order lanes. A value of 0, or a value above the lane count, means all lanes. Lanes at or above the active count carry 0 on `tx_data` and are ignored by the comparison.
- R3: `tx_valid` and `rx_ready` are 0 during reset and 1 from the first cycle after it. `tx_data` changes only on a cycle after a handshake (`tx_valid` and `tx_ready` both high); it is held stable while `tx_ready` is low.
- R4: Alignment scans delay offsets 0 to OFS-1, one per received word. A matching word moves the checker to verification, which needs VER consecutive matching words at that offset before `locked` rises. A mismatch during verification resumes the scan at the next offset. `locked` cannot rise before VER+1 words have been received.
- R5: One cycle after each accepted receive word, `rx_mon` holds that word and `err_vec` holds (received XOR expected) restricted to the active lanes. On a clean, aligned link `err_vec` stays 0.
- R6: A pulse on `err_inject` flips bit 0 of the word loaded at the next transmit handshake. The expected copy is left intact, so exactly one `err_vec` sample equal to 1 and one counted error result.
- R7: While locked, a received word that leaves more than LIM mismatching words among the last WIN received words drops `locked` and restarts the scan at offset 0. Exactly LIM mismatching words in every window keeps the lock.
- R8: `err_cnt` adds the number of set bits of `err_vec` for each word compared while locked. It does not change for words compared while searching or verifying.
- R9: `err_cnt` saturates at its all-ones value.
- R10: A synchronous, active-high `rst` restarts the generator, the alignment state machine, the outputs and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high user reset |
| err_inject | input | 1 | One-cycle request to corrupt the next loaded word |
| wsel | input | $clog2(LANES+1) | Active lane count (0 means all) |
| tx_data | output | LANES | Transmit word |
| tx_valid | output | 1 | Transmit word is valid |
| tx_ready | input | 1 | Loopback accepts the transmit word |
| rx_data | input | LANES | Returned word |
| rx_valid | input | 1 | Returned word is valid |
| rx_ready | output | 1 | Checker accepts the returned word |
| rx_mon | output | LANES | Registered copy of the last accepted word |
| err_vec | output | LANES | Per-lane mismatch of the last accepted word |
| locked | output | 1 | Alignment confirmed and comparison active |
| err_cnt | output | CNT_W | Saturating count of mismatching bits while locked |

## Verification
The bench builds the block with 8 lanes, a 32-entry offset range and an 8-bit error counter. The narrow counter lets alternating all-lane corruption drive it to saturation within a few hundred cycles. That run also holds the unlock threshold exactly at its limit, so one stimulus covers both the saturation point and the boundary that keeps the lock. The full 32-entry range lets a loopback delay of one word and one of 32 words reach both ends of the offset scan. Widths of one lane down to a single bit make the unlock count exact: nine corrupted words leave a count of nine that must then stay frozen.

// File: rtl/prbs_lt_pkg.sv
package prbs_lt_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } align_st_e;

  localparam logic [6:0] PRBS_SEED = 7'h7F;

  // One step of x^7 + x^6 + 1: new bit = s[6] ^ s[5], shifted in at bit 0.
  function automatic logic [6:0] prbs_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

endpackage

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_lt_pkg::*;
#(
  parameter int W   = 8,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [WSW-1:0] eff_w,
  input  logic           err_inject,
  input  logic           tx_ready,
  output logic [W-1:0]   tx_data,
  output logic           tx_valid,
  output logic [W-1:0]   clean_word
);

  localparam logic [W-1:0] FLIP_BIT = W'(1);

  typedef struct packed {
    logic [6:0]   st;
    logic [W-1:0] wd;
  } gen_t;

  function automatic gen_t advance(input logic [6:0] s0, input logic [WSW-1:0] n);
    gen_t r;
    r.st = s0;
    r.wd = '0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(n)) begin
        r.st = prbs_step(r.st);
        r.wd[i] = r.st[0];
      end
    end
    return r;
  endfunction

  logic [6:0]   lfsr_q;
  logic [W-1:0] word_q;
  logic         flip_q;
  logic         pend_q;
  logic         run_q;
  logic         fire;
  gen_t         from_seed;
  gen_t         from_state;

  assign fire       = run_q && tx_ready;
  assign from_seed  = advance(PRBS_SEED, eff_w);
  assign from_state = advance(lfsr_q, eff_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= from_seed.st;
      word_q <= from_seed.wd;
      flip_q <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (fire) begin
        lfsr_q <= from_state.st;
        word_q <= from_state.wd;
        flip_q <= pend_q;
        pend_q <= err_inject;
      end else begin
        pend_q <= pend_q | err_inject;
      end
    end
  end

  assign tx_data    = word_q ^ (flip_q ? FLIP_BIT : '0);
  assign tx_valid   = run_q;
  assign clean_word = word_q;

  a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && !tx_ready) |=> $stable(tx_data));

  a_r1_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != 7'd0);

endmodule

// File: rtl/prbs_align_chk.sv
module prbs_align_chk
  import prbs_lt_pkg::*;
#(
  parameter int W   = 8,
  parameter int OFS = 32,
  parameter int VER = 16,
  parameter int WIN = 16,
  parameter int LIM = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_fire,
  input  logic [W-1:0] tx_clean,
  input  logic [W-1:0] lane_mask,
  input  logic         rx_fire,
  input  logic [W-1:0] rx_data,
  output logic         locked,
  output logic [W-1:0] err_vec,
  output logic [W-1:0] rx_mon,
  output logic         cmp_locked
);

  localparam int OFS_W = (OFS > 1) ? $clog2(OFS) : 1;
  localparam int VC_W  = (VER > 1) ? $clog2(VER) : 1;
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(OFS - 1);
  localparam logic [VC_W-1:0]  VER_LAST = VC_W'(VER - 1);

  logic [W-1:0]     hist [OFS];
  align_st_e        st_q;
  logic [OFS_W-1:0] ofs_q;
  logic [VC_W-1:0]  vcnt_q;
  logic [WIN-1:0]   bad_q;
  logic [W-1:0]     diff;
  logic             match;
  logic [WIN-1:0]   win_n;
  logic [OFS_W-1:0] ofs_inc;

  // Shift register of sent clean words, newest at index 0.
  always_ff @(posedge clk) begin
    if (tx_fire) begin
      hist[0] <= tx_clean;
      for (int k = 1; k < OFS; k++) hist[k] <= hist[k-1];
    end
  end

  assign diff    = (rx_data ^ hist[ofs_q]) & lane_mask;
  assign match   = (diff == '0);
  assign win_n   = {bad_q[WIN-2:0], !match};
  assign ofs_inc = (ofs_q == OFS_LAST) ? '0 : ofs_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_SEARCH;
      ofs_q      <= '0;
      vcnt_q     <= '0;
      bad_q      <= '0;
      err_vec    <= '0;
      rx_mon     <= '0;
      cmp_locked <= 1'b0;
    end else begin
      cmp_locked <= rx_fire && (st_q == ST_LOCKED);
      if (rx_fire) begin
        err_vec <= diff;
        rx_mon  <= rx_data;
        unique case (st_q)
          ST_SEARCH: begin
            if (match) begin
              st_q   <= ST_VERIFY;
              vcnt_q <= '0;
            end else begin
              ofs_q <= ofs_inc;
            end
          end
          ST_VERIFY: begin
            if (!match) begin
              st_q  <= ST_SEARCH;
              ofs_q <= ofs_inc;
            end else if (vcnt_q == VER_LAST) begin
              st_q  <= ST_LOCKED;
              bad_q <= '0;
            end else begin
              vcnt_q <= vcnt_q + 1'b1;
            end
          end
          default: begin
            if ($countones(win_n) > LIM) begin
              st_q  <= ST_SEARCH;
              ofs_q <= '0;
            end
            bad_q <= win_n;
          end
        endcase
      end
    end
  end

  assign locked = (st_q == ST_LOCKED);

  a_r4_lock_on_clean_word: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (err_vec == '0));

  a_r7_unlock_on_bad_word: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rst)) |-> (err_vec != '0));

endmodule

// File: rtl/prbs_err_cnt.sv
module prbs_err_cnt #(
  parameter int W     = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [W-1:0]     err_vec,
  output logic [CNT_W-1:0] cnt
);

  typedef logic [CNT_W:0] wide_t;

  wide_t sum;

  assign sum = wide_t'(cnt) + wide_t'($countones(err_vec));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  a_r8_frozen_unless_locked: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));

  a_r9_saturated_stays: assert property (@(posedge clk) disable iff (rst)
    (&cnt) |=> (&cnt));

  a_r8_never_decreases: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt >= $past(cnt)));

endmodule

// File: rtl/prbs_link_tester.sv
module prbs_link_tester #(
  parameter int LANES = 8,
  parameter int OFS   = 32,
  parameter int VER   = 16,
  parameter int WIN   = 16,
  parameter int LIM   = 8,
  parameter int CNT_W = 32,
  localparam int WSW  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             err_inject,
  input  logic [WSW-1:0]   wsel,
  output logic [LANES-1:0] tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [LANES-1:0] rx_data,
  input  logic             rx_valid,
  output logic             rx_ready,
  output logic [LANES-1:0] rx_mon,
  output logic [LANES-1:0] err_vec,
  output logic             locked,
  output logic [CNT_W-1:0] err_cnt
);

  localparam logic [WSW-1:0] FULL_W = WSW'(LANES);

  logic [WSW-1:0]   eff_w;
  logic [LANES-1:0] lane_mask;
  logic [LANES-1:0] clean_word;
  logic             tx_fire;
  logic             rx_fire;
  logic             cmp_locked;

  assign eff_w = (wsel == '0 || wsel > FULL_W) ? FULL_W : wsel;

  always_comb begin
    for (int i = 0; i < LANES; i++) lane_mask[i] = (i < int'(eff_w));
  end

  assign tx_fire  = tx_valid && tx_ready;
  assign rx_ready = tx_valid;
  assign rx_fire  = rx_valid && rx_ready;

  prbs_tx_gen #(.W(LANES), .WSW(WSW)) u_gen (
    .clk        (clk),
    .rst        (rst),
    .eff_w      (eff_w),
    .err_inject (err_inject),
    .tx_ready   (tx_ready),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .clean_word (clean_word)
  );

  prbs_align_chk #(.W(LANES), .OFS(OFS), .VER(VER), .WIN(WIN), .LIM(LIM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_fire    (tx_fire),
    .tx_clean   (clean_word),
    .lane_mask  (lane_mask),
    .rx_fire    (rx_fire),
    .rx_data    (rx_data),
    .locked     (locked),
    .err_vec    (err_vec),
    .rx_mon     (rx_mon),
    .cmp_locked (cmp_locked)
  );

  prbs_err_cnt #(.W(LANES), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .en      (cmp_locked),
    .err_vec (err_vec),
    .cnt     (err_cnt)
  );

  a_r2_idle_lanes_zero: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> ((tx_data & ~lane_mask) == '0));

  a_r3_ready_follows_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tx_valid && rx_ready));

endmodule

// File: tb/sim_prbs_link_tester.sv
module sim_prbs_link_tester;

  localparam int LANES = 8;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             err_inject;
  logic [3:0]       wsel;
  logic [LANES-1:0] tx_data;
  logic             tx_valid;
  logic             tx_ready;
  logic [LANES-1:0] rx_data;
  logic             rx_valid;
  logic             rx_ready;
  logic [LANES-1:0] rx_mon;
  logic [LANES-1:0] err_vec;
  logic             locked;
  logic [CNT_W-1:0] err_cnt;

  int checks = 0;
  int errors = 0;
  int dly    = 1;
  int mode   = 0;

  logic [LANES-1:0] pipe  [32];
  logic             vpipe [32];
  logic             alt;
  logic [LANES-1:0] rx_prev;
  logic [LANES-1:0] cmask;

  always #2.5 clk = ~clk;

  prbs_link_tester #(.LANES(LANES), .OFS(32), .VER(16), .WIN(16), .LIM(8), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .err_inject(err_inject), .wsel(wsel),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_mon(rx_mon), .err_vec(err_vec), .locked(locked), .err_cnt(err_cnt)
  );

  // Loopback model: a delay line of dly cycles with optional corruption.
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 32; k++) begin
        pipe[k]  <= '0;
        vpipe[k] <= 1'b0;
      end
    end else begin
      pipe[0]  <= tx_data;
      vpipe[0] <= tx_valid && tx_ready;
      for (int k = 1; k < 32; k++) begin
        pipe[k]  <= pipe[k-1];
        vpipe[k] <= vpipe[k-1];
      end
    end
    alt     <= !alt;
    rx_prev <= rx_data;
  end

  assign cmask    = (mode == 2) ? '1 : ((mode == 1 && alt) ? '1 : '0);
  assign rx_data  = pipe[dly-1] ^ cmask;
  assign rx_valid = vpipe[dly-1];

  function automatic int eff_of(input int w);
    return (w == 0 || w > LANES) ? LANES : w;
  endfunction

  // Pattern model from R1: new bit = s[6]^s[5], shifted into bit 0, fills word from bit 0.
  function automatic logic [LANES-1:0] bgen(inout logic [6:0] s, input int n);
    logic [LANES-1:0] w = '0;
    for (int i = 0; i < LANES; i++) begin
      if (i < n) begin
        s = {s[5:0], s[6] ^ s[5]};
        w[i] = s[0];
      end
    end
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int w, input int d);
    @(negedge clk);
    rst = 1'b1; wsel = 4'(w); dly = d; mode = 0; err_inject = 1'b0; tx_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_lock(input string tag);
    int n = 0;
    while (!locked && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(locked, tag, 32'(locked), 32'd1);
  endtask

  task automatic inject_once(input string tag, input logic [CNT_W-1:0] base);
    int seen = 0;
    logic [LANES-1:0] val = '0;
    err_inject = 1'b1;
    @(negedge clk);
    err_inject = 1'b0;
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      if (err_vec != '0) begin
        seen++;
        val = err_vec;
      end
    end
    chk(seen == 1, {tag, " R6 one bad sample"}, 32'(seen), 32'd1);
    chk(val == LANES'(1), {tag, " R6 bit0 flipped"}, 32'(val), 32'd1);
    chk(err_cnt == base + 1'b1, {tag, " R8 count +1"}, 32'(err_cnt), 32'(base + 1'b1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] ms;
    logic [LANES-1:0] expw;
    void'($urandom(32'd4242));
    rst = 1'b1; err_inject = 1'b0; wsel = 4'd8; tx_ready = 1'b1; alt = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!locked, "R10 locked in reset", 32'(locked), 0);
    chk(err_cnt == '0, "R10 count in reset", 32'(err_cnt), 0);
    chk(!tx_valid && !rx_ready, "R3 valid low in reset", 32'({tx_valid, rx_ready}), 0);

    // R1/R3: sequence with a stall
    do_reset(8, 1);
    chk(tx_valid && rx_ready, "R3 valid after reset", 32'({tx_valid, rx_ready}), 32'd3);
    ms = 7'h7F;
    expw = bgen(ms, 8);
    for (int k = 0; k < 14; k++) begin
      chk(tx_data == expw, "R1 word sequence", 32'(tx_data), 32'(expw));
      if (k == 5) begin
        tx_ready = 1'b0;
        for (int j = 0; j < 3; j++) begin
          @(negedge clk);
          chk(tx_data == expw, "R3 stall holds word", 32'(tx_data), 32'(expw));
        end
        tx_ready = 1'b1;
      end
      @(negedge clk);
      expw = bgen(ms, 8);
    end

    // R2: narrow width and out-of-range width
    for (int t = 0; t < 3; t++) begin
      int w = (t == 0) ? 3 : ((t == 1) ? 0 : 12);
      do_reset(w, 5);
      ms = 7'h7F;
      for (int k = 0; k < 6; k++) begin
        expw = bgen(ms, eff_of(w));
        chk(tx_data == expw, "R2 width select", 32'(tx_data), 32'(expw));
        @(negedge clk);
      end
    end

    // R4/R5/R6 directed: shortest delay
    do_reset(8, 1);
    repeat (10) @(negedge clk);
    chk(!locked, "R4 no early lock", 32'(locked), 0);
    wait_lock("R4 lock delay 1");
    repeat (40) @(negedge clk);
    chk(err_cnt == '0, "R8 clean count", 32'(err_cnt), 0);
    chk(err_vec == '0, "R5 clean err_vec", 32'(err_vec), 0);
    chk(rx_mon == rx_prev, "R5 rx_mon copy", 32'(rx_mon), 32'(rx_prev));
    inject_once("d1", '0);

    // Longest delay reaches the last offset
    do_reset(8, 32);
    wait_lock("R4 lock delay 32");
    repeat (20) @(negedge clk);
    chk(err_vec == '0, "R5 clean at offset 31", 32'(err_vec), 0);
    inject_once("d32", '0);

    // Random widths and delays
    for (int it = 0; it < 5; it++) begin
      int w = 1 + int'($urandom_range(7));
      int d = 1 + int'($urandom_range(31));
      do_reset(w, d);
      wait_lock("R4 lock random");
      repeat (int'($urandom_range(30))) @(negedge clk);
      chk(err_vec == '0, "R5 clean random", 32'(err_vec), 0);
      inject_once("rand", '0);
    end

    // R7/R8: full corruption on one lane unlocks after exactly 9 bad words
    do_reset(1, 1 + int'($urandom_range(31)));
    wait_lock("R4 lock width 1");
    mode = 2;
    repeat (40) @(negedge clk);
    chk(!locked, "R7 unlock on 9 bad", 32'(locked), 0);
    chk(err_cnt == 8'd9, "R8 count 9 bad words", 32'(err_cnt), 32'd9);
    repeat (100) @(negedge clk);
    chk(err_cnt == 8'd9, "R8 frozen while searching", 32'(err_cnt), 32'd9);
    chk(!locked, "R7 no relock on corrupt", 32'(locked), 0);
    mode = 0;
    wait_lock("R4 relock");

    // R7 boundary and R9 saturation: alternating corrupted words
    do_reset(8, 7);
    wait_lock("R4 lock before alternation");
    mode = 1;
    repeat (300) @(negedge clk);
    chk(locked, "R7 exactly 8 of 16 keeps lock", 32'(locked), 32'd1);
    chk(err_cnt == 8'hFF, "R9 saturates", 32'(err_cnt), 32'hFF);

    // R10 user reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mode = 0;
    ms = 7'h7F;
    expw = bgen(ms, 8);
    chk(err_cnt == '0, "R10 count cleared", 32'(err_cnt), 0);
    chk(!locked, "R10 lock cleared", 32'(locked), 0);
    chk(tx_data == expw, "R10 generator restarted", 32'(tx_data), 32'(expw));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule